// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional

This block holds a single processor reservation for word-sized atomic read-modify-write sequences. A reserving load captures its effective address and marks the reservation live. The reservation also notes a length of one word. A later conditional store is compared against that record. The store may write memory only if the reservation is live, the noted length is one word, the store address is word aligned and the store address equals the captured one.

The verdict is given in the same cycle as the conditional-store strobe. It appears as a memory write enable and as a 4-bit condition field. In that field, bit 1 reports success and bit 0 copies the incoming summary-overflow bit. Any conditional store ends the reservation, whether it succeeds or fails. A clear input lets surrounding logic cancel the reservation, for example when another agent writes the line.

Top module: `rsv_monitor`

## Requirements
- R1: After reset no reservation is held. A conditional store before any reserving load fails, with `mem_wr_en` low and `cond_field[1]` low.
- R2: A reserving load records its address. A later aligned conditional store to the same address succeeds in its own strobe cycle: `mem_wr_en` is 1 and `cond_field[1]` is 1.
- R3: A conditional store whose address differs from the recorded one fails.
- R4: During a conditional store, `cond_field` is {2'b00, success, sum_ovf}, so bit 1 carries the verdict and bit 0 copies `sum_ovf`. Outside a store cycle, `cond_field` is 4'b0000.
- R5: Every conditional store ends the reservation. A second store to the same address, with no new reserving load in between, fails.
- R6: A new reserving load replaces the held address. A store to the older address then fails, and a store to the newer address succeeds.
- R7: A pulse on `rsv_clear` drops the reservation. When `rsv_clear` and `rsv_load` are high in the same cycle, the clear wins and no reservation remains.
- R8: A conditional store whose address has either of bits [1:0] set fails, even if that address equals the recorded one.
- R9: When `rsv_load` and `cond_store` are high in the same cycle, the store is judged against the reservation held before that cycle, and no reservation remains afterwards.
- R10: `mem_wr_en` is high only in a cycle where `cond_store` is high and the store succeeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_load | input | 1 | Reserving word load strobe |
| cond_store | input | 1 | Conditional store strobe |
| rsv_clear | input | 1 | Drop the reservation |
| eff_addr | input | 32 | Effective address of the current load or store |
| sum_ovf | input | 1 | Summary-overflow bit copied into the result |
| mem_wr_en | output | 1 | Memory write permission for the conditional store |
| cond_field | output | 4 | Condition result of the conditional store |

## Verification
The two functions that can fall in the same cycle are taking a new reservation and judging a conditional store. Clearing can also land on the same edge as a reservation. The bench provokes these collisions on purpose: it raises `rsv_load` and `cond_store` together, first with a live matching reservation and then with none. It also raises `rsv_clear` and `rsv_load` together. It then judges the outcome twice: by the verdict in the collision cycle, and by a follow-up store to the same address, which must fail. A random phase afterwards mixes all strobes over a small address set, so that hits, misses and collisions recur, and a behavioural model is compared on every clock.

// File: rtl/rsvmon_pkg.sv
package rsvmon_pkg;
   localparam int unsigned RES_W      = 4;
   localparam int unsigned RES_OK_BIT = 1;
   localparam int unsigned RES_SO_BIT = 0;

   function automatic logic [RES_W-1:0] make_result(input logic ok, input logic so);
      logic [RES_W-1:0] r;
      r             = '0;
      r[RES_OK_BIT] = ok;
      r[RES_SO_BIT] = so;
      return r;
   endfunction
endpackage

// File: rtl/rsv_track.sv
module rsv_track #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned LEN_W      = $clog2(WORD_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              drop,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              held,
   output logic [LEN_W-1:0]  held_len,
   output logic [ADDR_W-1:0] held_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held      <= 1'b0;
         held_len  <= '0;
         held_addr <= '0;
      end else if (drop) begin
         held      <= 1'b0;
      end else if (take) begin
         held      <= 1'b1;
         held_len  <= LEN_W'(WORD_BYTES);
         held_addr <= addr_in;
      end
   end
endmodule

// File: rtl/rsv_judge.sv
module rsv_judge #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned WORD_BYTES  = 4,
   parameter int unsigned LEN_W       = $clog2(WORD_BYTES) + 1,
   parameter bit          ALIGN_CHECK = 1'b1
) (
   input  logic              strobe,
   input  logic              held,
   input  logic [LEN_W-1:0]  held_len,
   input  logic [ADDR_W-1:0] held_addr,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              pass
);
   localparam int unsigned OFF_W = $clog2(WORD_BYTES);

   logic aligned;
   logic len_ok;
   logic addr_eq;

   generate
      if (ALIGN_CHECK && OFF_W > 0) begin : g_align
         assign aligned = (addr_in[OFF_W-1:0] == '0);
      end else begin : g_noalign
         assign aligned = 1'b1;
      end
   endgenerate

   assign len_ok  = (held_len == LEN_W'(WORD_BYTES));
   assign addr_eq = (held_addr == addr_in);
   assign pass    = strobe && held && len_ok && addr_eq && aligned;
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned WORD_BYTES  = 4,
   parameter bit          ALIGN_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsv_load,
   input  logic              cond_store,
   input  logic              rsv_clear,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic              sum_ovf,
   output logic              mem_wr_en,
   output logic [3:0]        cond_field
);
   import rsvmon_pkg::*;

   localparam int unsigned LEN_W = $clog2(WORD_BYTES) + 1;

   generate
      if (WORD_BYTES == 0 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("rsv_monitor: WORD_BYTES must be a power of two");
      end
      if (ADDR_W <= $clog2(WORD_BYTES)) begin : g_bad_addr
         $error("rsv_monitor: ADDR_W too small for WORD_BYTES");
      end
      if (RES_W != 4) begin : g_bad_res
         $error("rsv_monitor: result field must be 4 bits");
      end
   endgenerate

   logic              held;
   logic [LEN_W-1:0]  held_len;
   logic [ADDR_W-1:0] held_addr;
   logic              pass;

   rsv_judge #(
      .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W), .ALIGN_CHECK(ALIGN_CHECK)
   ) judge_i (
      .strobe(cond_store), .held(held), .held_len(held_len),
      .held_addr(held_addr), .addr_in(eff_addr), .pass(pass)
   );

   rsv_track #(
      .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W)
   ) track_i (
      .clk(clk), .rst_n(rst_n), .take(rsv_load),
      .drop(rsv_clear | cond_store), .addr_in(eff_addr),
      .held(held), .held_len(held_len), .held_addr(held_addr)
   );

   assign mem_wr_en  = pass;
   assign cond_field = cond_store ? make_result(pass, sum_ovf) : '0;
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rsv_load,
   input logic              cond_store,
   input logic              rsv_clear,
   input logic [ADDR_W-1:0] eff_addr,
   input logic              sum_ovf,
   input logic              mem_wr_en,
   input logic [3:0]        cond_field,
   input logic              held
);
   a_r10_wr_only_on_store: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (cond_store && cond_field[1]));

   a_r4_so_copied: assert property (@(posedge clk) disable iff (!rst_n)
      cond_store |-> (cond_field[0] == sum_ovf && cond_field[3:2] == 2'b00));

   a_r4_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cond_store |-> (cond_field == 4'b0000));

   a_r5_store_ends_rsv: assert property (@(posedge clk) disable iff (!rst_n)
      cond_store |=> !held);

   a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_clear |=> !held);

   a_r8_misaligned_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_store && eff_addr[1:0] != 2'b00) |-> !mem_wr_en);

   a_r1_no_rsv_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !held |-> !mem_wr_en);
endmodule

bind rsv_monitor rsv_monitor_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .rsv_load(rsv_load), .cond_store(cond_store),
   .rsv_clear(rsv_clear), .eff_addr(eff_addr), .sum_ovf(sum_ovf),
   .mem_wr_en(mem_wr_en), .cond_field(cond_field), .held(held)
);

// File: tb/rsv_monitor_tb_top.sv
`timescale 1ns/1ps
module rsv_monitor_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rsv_load = 1'b0;
   logic        cond_store = 1'b0;
   logic        rsv_clear = 1'b0;
   logic [31:0] eff_addr = '0;
   logic        sum_ovf = 1'b0;
   logic        mem_wr_en;
   logic [3:0]  cond_field;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural reference state
   bit          m_valid = 1'b0;
   logic [31:0] m_addr  = '0;

   always #2.5 clk = ~clk;

   rsv_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .rsv_load(rsv_load), .cond_store(cond_store),
      .rsv_clear(rsv_clear), .eff_addr(eff_addr), .sum_ovf(sum_ovf),
      .mem_wr_en(mem_wr_en), .cond_field(cond_field)
   );

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {wr,field} actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: drive after the falling edge, compare, then advance the model at the rising edge
   task automatic step(input string tag, input bit ld, input bit st, input bit clr,
                       input logic [31:0] a, input bit so);
      bit ok;
      logic [3:0] ef;
      @(negedge clk);
      rsv_load = ld; cond_store = st; rsv_clear = clr; eff_addr = a; sum_ovf = so;
      #1;
      ok = st && m_valid && (m_addr == a) && (a[1:0] == 2'b00);
      ef = st ? {2'b00, ok, so} : 4'b0000;
      check(tag, {mem_wr_en, cond_field}, {ok, ef});
      @(posedge clk);
      if (rst_n) begin
         if (st || clr) m_valid = 1'b0;
         else if (ld) begin m_valid = 1'b1; m_addr = a; end
      end
   endtask

   initial begin
      #100000;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: nothing held after reset
      step("R1", 0, 1, 0, 32'h0000_0000, 0);
      step("R1", 0, 1, 0, 32'h0000_1000, 1);
      // R2 / R4: reserve then matching store, with and without overflow
      step("R4", 1, 0, 0, 32'h0000_1000, 1);
      step("R2", 0, 1, 0, 32'h0000_1000, 0);
      step("R2", 1, 0, 0, 32'h0000_2000, 0);
      step("R4", 0, 1, 0, 32'h0000_2000, 1);
      // R5: reservation gone after a store
      step("R5", 0, 1, 0, 32'h0000_2000, 0);
      // R3: mismatch fails and also ends reservation
      step("R3", 1, 0, 0, 32'h0000_3000, 0);
      step("R3", 0, 1, 0, 32'h0000_3004, 0);
      step("R5", 0, 1, 0, 32'h0000_3000, 0);
      // R6: newer reservation replaces older
      step("R6", 1, 0, 0, 32'h0000_4000, 0);
      step("R6", 1, 0, 0, 32'h0000_5000, 0);
      step("R6", 0, 1, 0, 32'h0000_4000, 0);
      step("R6", 1, 0, 0, 32'h0000_4000, 0);
      step("R6", 1, 0, 0, 32'h0000_5000, 0);
      step("R6", 0, 1, 0, 32'h0000_5000, 0);
      // R7: clear drops; clear beats simultaneous load
      step("R7", 1, 0, 0, 32'h0000_6000, 0);
      step("R7", 0, 0, 1, 32'h0000_6000, 0);
      step("R7", 0, 1, 0, 32'h0000_6000, 0);
      step("R7", 1, 0, 1, 32'h0000_6000, 0);
      step("R7", 0, 1, 0, 32'h0000_6000, 0);
      // R8: misaligned address equal to the recorded one still fails
      step("R8", 1, 0, 0, 32'h0000_7002, 0);
      step("R8", 0, 1, 0, 32'h0000_7002, 1);
      step("R8", 1, 0, 0, 32'h0000_7001, 0);
      step("R8", 0, 1, 0, 32'h0000_7001, 0);
      // R9: load and store together, judged on prior state, nothing left
      step("R9", 1, 0, 0, 32'h0000_8000, 0);
      step("R9", 1, 1, 0, 32'h0000_8000, 0);
      step("R9", 0, 1, 0, 32'h0000_8000, 0);
      step("R9", 1, 1, 0, 32'h0000_9000, 1);
      step("R9", 0, 1, 0, 32'h0000_9000, 0);
      // R10: random mix over a small address set
      for (int i = 0; i < 400; i++) begin
         int r;
         logic [31:0] a;
         r = $urandom;
         a = 32'h0000_A000 + {28'd0, r[3:2], r[5:4] == 2'b11 ? 2'b10 : 2'b00};
         step("R10", r[8] | r[9], r[10] & r[11], r[12] & r[13] & r[14], a, r[15]);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule